// File: doc/BRIEF.md
# VGA Sync Timing Generator

This block derives horizontal and vertical synchronisation for a VGA-style raster from a single pixel-rate clock, 40 MHz by default. A free-running horizontal counter sets the line period and places the horizontal sync pulse. A line counter advances once per line and drives a four-phase vertical sequencer: back porch, visible, front porch and sync. Downstream pixel logic uses a one-cycle line-start strobe and a visible-region flag to time its fetches.

The vertical timing is event driven. On each line boundary the sequencer looks at the line number it is entering and decides whether to change phase. The line counter is cleared when the sync phase ends, not at the top of the picture. A change in the vertical sync level is decided on one line boundary and appears at the next one. The period, the sync position and width, the phase thresholds and both sync polarities are parameters.

Top module: `vga_sync_gen`

## Requirements
- R1: The horizontal count runs 0, 1, … H_LAST and then returns to 0, so a line lasts H_LAST+1 cycles. `line_start_o` is high for exactly the one cycle in which the count is 0 after a wrap. It stays low in the first line after reset.
- R2: The horizontal sync is active while the horizontal count lies in [HSYNC_AT, HSYNC_AT+HSYNC_LEN) and inactive otherwise. With the default active-low setting, active means 0 on the pin.
- R3: The line number L starts at 0 and rises by one on every line boundary. Lines are grouped by L: back porch for L < VIEW_AT, visible for VIEW_AT ≤ L < FRONT_AT, front porch for FRONT_AT ≤ L < VSYNC_AT, and sync for VSYNC_AT ≤ L < VSYNC_END.
- R4: `visible_o` is 1 only during visible-phase lines, and only while the horizontal count is below HSYNC_AT.
- R5: On the boundary where L would reach VSYNC_END, L is cleared to 0 and the sequencer returns to back porch. A frame is therefore VSYNC_END lines long.
- R6: The vertical sync becomes active at the line start one line after the sync phase is entered, that is on line VSYNC_AT+1. It becomes inactive at the line start one line after the phase is left, that is on line 1 of the following frame. It stays active for VSYNC_END−VSYNC_AT lines and changes level only in a line-start cycle.
- R7: While reset is held and directly after it, both sync pins are at their inactive level (high by default), `visible_o` is 0 and `line_start_o` is 0.
- R8: A synchronous active-high reset applied mid-frame returns both counters and the sequencer to their initial values. Timing then restarts exactly as it does after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_o | output | 1 | Horizontal sync pin, polarity set by parameter |
| vsync_o | output | 1 | Vertical sync pin, polarity set by parameter |
| visible_o | output | 1 | High during the visible part of a visible line |
| line_start_o | output | 1 | One-cycle strobe on the first cycle of each line |

## Verification
The assertions take for granted that reset is held for at least one clock edge before timing is judged, since every check is disabled while reset is high. They also assume the parameters satisfy the ordering checked at elaboration: the sync pulse ends inside the line, and the four vertical thresholds rise strictly with a non-empty back porch. The bench holds reset only on whole cycles, driven away from the clock edge. It picks small parameter values that meet the ordering, so that several complete frames and a reset in the middle of a frame fit in a short run.

// File: rtl/vga_sync_pkg.sv
package vga_sync_pkg;

   typedef enum logic [1:0] {
      PH_BACK  = 2'd0,
      PH_VIEW  = 2'd1,
      PH_FRONT = 2'd2,
      PH_SYNC  = 2'd3
   } vphase_e;

endpackage

// File: rtl/vsg_line_timer.sv
module vsg_line_timer #(
   parameter int H_LAST     = 1254,
   parameter int HSYNC_AT   = 800,
   parameter int HSYNC_LEN  = 96,
   localparam int HW        = $clog2(H_LAST + 1)
) (
   input  logic          clk,
   input  logic          rst,
   output logic [HW-1:0] hcnt,
   output logic          wrap,
   output logic          hs_act,
   output logic          pre_sync
);

   localparam logic [HW-1:0] C_LAST  = HW'(H_LAST);
   localparam logic [HW-1:0] C_HS_ON = HW'(HSYNC_AT);
   localparam logic [HW-1:0] C_HS_OFF = HW'(HSYNC_AT + HSYNC_LEN);

   assign wrap     = (hcnt == C_LAST);
   assign hs_act   = (hcnt >= C_HS_ON) && (hcnt < C_HS_OFF);
   assign pre_sync = (hcnt < C_HS_ON);

   always_ff @(posedge clk) begin
      if (rst) begin
         hcnt <= '0;
      end else if (wrap) begin
         hcnt <= '0;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

   // R1: counter wraps to zero after its last value
   a_r1_wrap_zero: assert property (@(posedge clk) disable iff (rst)
      (hcnt == C_LAST) |=> (hcnt == '0));
   // R1: counter otherwise steps by one
   a_r1_step: assert property (@(posedge clk) disable iff (rst)
      (hcnt != C_LAST) |=> (hcnt == $past(hcnt) + 1'b1));
   // R2: sync pulse begins only at its start count
   a_r2_hs_start: assert property (@(posedge clk) disable iff (rst)
      $rose(hs_act) |-> (hcnt == C_HS_ON));
   // R2: sync pulse ends only at its end count
   a_r2_hs_end: assert property (@(posedge clk) disable iff (rst)
      $fell(hs_act) |-> (hcnt == C_HS_OFF));

endmodule

// File: rtl/vsg_frame_seq.sv
module vsg_frame_seq
   import vga_sync_pkg::*;
#(
   parameter int VIEW_AT    = 15,
   parameter int FRONT_AT   = 527,
   parameter int VSYNC_AT   = 529,
   parameter int VSYNC_END  = 531,
   localparam int VW        = $clog2(VSYNC_END + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wrap,
   output vphase_e       phase,
   output logic [VW-1:0] lcnt,
   output logic          vs_act,
   output logic          lstart
);

   localparam logic [VW-1:0] C_VIEW  = VW'(VIEW_AT);
   localparam logic [VW-1:0] C_FRONT = VW'(FRONT_AT);
   localparam logic [VW-1:0] C_VS    = VW'(VSYNC_AT);
   localparam logic [VW-1:0] C_END   = VW'(VSYNC_END);

   logic [VW-1:0] nxt;
   logic          vs_arm;

   assign nxt = lcnt + 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         lcnt   <= '0;
         phase  <= PH_BACK;
         vs_arm <= 1'b0;
         vs_act <= 1'b0;
         lstart <= 1'b0;
      end else begin
         lstart <= wrap;
         if (wrap) begin
            vs_act <= vs_arm;
            lcnt   <= nxt;
            unique case (phase)
               PH_BACK:  if (nxt >= C_VIEW)  phase <= PH_VIEW;
               PH_VIEW:  if (nxt >= C_FRONT) phase <= PH_FRONT;
               PH_FRONT: if (nxt >= C_VS) begin
                  phase  <= PH_SYNC;
                  vs_arm <= 1'b1;
               end
               PH_SYNC:  if (nxt >= C_END) begin
                  phase  <= PH_BACK;
                  lcnt   <= '0;
                  vs_arm <= 1'b0;
               end
               default:  phase <= PH_BACK;
            endcase
         end
      end
   end

   // R5: line number never reaches the frame length
   a_r5_lcnt_bound: assert property (@(posedge clk) disable iff (rst)
      lcnt < C_END);
   // R6: vertical sync level moves only with a line start
   a_r6_vs_on_line: assert property (@(posedge clk) disable iff (rst)
      !$stable(vs_act) |-> lstart);
   // R3: line number is unchanged inside a line
   a_r3_lcnt_hold: assert property (@(posedge clk) disable iff (rst)
      !lstart |-> $stable(lcnt));
   // R8: reset leaves counter and phase at their start values
   a_r8_reset_state: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (lcnt == '0 && phase == PH_BACK && !vs_act));

endmodule

// File: rtl/vsg_pin_level.sv
module vsg_pin_level #(
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic act,
   output logic pin
);

   generate
      if (ACTIVE_LOW) begin : g_low
         assign pin = ~act;
      end else begin : g_high
         assign pin = act;
      end
   endgenerate

endmodule

// File: rtl/vga_sync_gen.sv
module vga_sync_gen
   import vga_sync_pkg::*;
#(
   parameter int H_LAST       = 1254,
   parameter int HSYNC_AT     = 800,
   parameter int HSYNC_LEN    = 96,
   parameter bit HS_ACT_LOW   = 1'b1,
   parameter int VIEW_AT      = 15,
   parameter int FRONT_AT     = 527,
   parameter int VSYNC_AT     = 529,
   parameter int VSYNC_END    = 531,
   parameter bit VS_ACT_LOW   = 1'b1
) (
   input  logic clk,
   input  logic rst,
   output logic hsync_o,
   output logic vsync_o,
   output logic visible_o,
   output logic line_start_o
);

   localparam int HW = $clog2(H_LAST + 1);
   localparam int VW = $clog2(VSYNC_END + 1);

   generate
      if (HSYNC_LEN < 1 || HSYNC_AT + HSYNC_LEN > H_LAST) begin : g_bad_h
         $error("horizontal sync must lie inside the line");
      end
      if (VIEW_AT < 1 || FRONT_AT <= VIEW_AT || VSYNC_AT <= FRONT_AT
          || VSYNC_END <= VSYNC_AT) begin : g_bad_v
         $error("vertical thresholds must rise strictly from one");
      end
   endgenerate

   logic [HW-1:0] hcnt;
   logic          wrap, hs_act, pre_sync, vs_act, lstart;
   logic [VW-1:0] lcnt;
   vphase_e       phase;

   vsg_line_timer #(
      .H_LAST   (H_LAST),
      .HSYNC_AT (HSYNC_AT),
      .HSYNC_LEN(HSYNC_LEN)
   ) u_line (
      .clk     (clk),
      .rst     (rst),
      .hcnt    (hcnt),
      .wrap    (wrap),
      .hs_act  (hs_act),
      .pre_sync(pre_sync)
   );

   vsg_frame_seq #(
      .VIEW_AT  (VIEW_AT),
      .FRONT_AT (FRONT_AT),
      .VSYNC_AT (VSYNC_AT),
      .VSYNC_END(VSYNC_END)
   ) u_frame (
      .clk   (clk),
      .rst   (rst),
      .wrap  (wrap),
      .phase (phase),
      .lcnt  (lcnt),
      .vs_act(vs_act),
      .lstart(lstart)
   );

   vsg_pin_level #(.ACTIVE_LOW(HS_ACT_LOW)) u_hpin (.act(hs_act), .pin(hsync_o));
   vsg_pin_level #(.ACTIVE_LOW(VS_ACT_LOW)) u_vpin (.act(vs_act), .pin(vsync_o));

   assign visible_o    = (phase == PH_VIEW) && pre_sync;
   assign line_start_o = lstart;

   // R4: visible flag only in the visible phase
   a_r4_view_phase: assert property (@(posedge clk) disable iff (rst)
      visible_o |-> (phase == PH_VIEW));
   // R1: line start strobe lasts one cycle at count zero
   a_r1_strobe: assert property (@(posedge clk) disable iff (rst)
      line_start_o |-> (hcnt == '0) ##1 !line_start_o);
   // R7: horizontal counter restarts at zero after reset
   a_r7_h_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (hcnt == '0 && !line_start_o));

endmodule

// File: tb/tb_vga_sync_gen.sv
module tb_vga_sync_gen;

   localparam int CLK_NS    = 25;
   localparam int P_HLAST   = 19;
   localparam int P_HS_AT   = 12;
   localparam int P_HS_LEN  = 3;
   localparam int P_VIEW    = 3;
   localparam int P_FRONT   = 8;
   localparam int P_VS_AT   = 10;
   localparam int P_VS_END  = 12;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic hsync_o, vsync_o, visible_o, line_start_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   // behavioural reference
   int  m_h = 0;
   int  m_line = 0;
   int  m_wraps = 0;

   vga_sync_gen #(
      .H_LAST(P_HLAST), .HSYNC_AT(P_HS_AT), .HSYNC_LEN(P_HS_LEN),
      .HS_ACT_LOW(1'b1),
      .VIEW_AT(P_VIEW), .FRONT_AT(P_FRONT), .VSYNC_AT(P_VS_AT),
      .VSYNC_END(P_VS_END), .VS_ACT_LOW(1'b1)
   ) dut (
      .clk(clk), .rst(rst), .hsync_o(hsync_o), .vsync_o(vsync_o),
      .visible_o(visible_o), .line_start_o(line_start_o)
   );

   always #(CLK_NS/2) clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (rst) begin
         m_h = 0; m_line = 0; m_wraps = 0;
      end else if (m_h == P_HLAST) begin
         m_h = 0;
         m_line = (m_line + 1) % P_VS_END;
         m_wraps++;
      end else begin
         m_h++;
      end
   end

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b (h=%0d line=%0d)",
                  req, act, exp, m_h, m_line);
      end
   endtask

   task automatic compare_all();
      logic e_hs, e_vs, e_vis, e_ls;
      e_ls  = (m_wraps > 0) && (m_h == 0);                          // R1
      e_hs  = !((m_h >= P_HS_AT) && (m_h < P_HS_AT + P_HS_LEN));    // R2, low = active
      e_vis = (m_line >= P_VIEW) && (m_line < P_FRONT) && (m_h < P_HS_AT); // R3 R4
      e_vs  = !((m_wraps > 0) &&
                ((m_line > P_VS_AT && m_line < P_VS_END) || m_line == 0)); // R5 R6
      check("R1 line_start", line_start_o, e_ls);
      check("R2 hsync", hsync_o, e_hs);
      check("R4 visible", visible_o, e_vis);
      check("R6 vsync", vsync_o, e_vs);
   endtask

   initial begin
      // R7: idle levels during reset
      repeat (3) @(negedge clk);
      check("R7 hsync in reset", hsync_o, 1'b1);
      check("R7 vsync in reset", vsync_o, 1'b1);
      check("R7 visible in reset", visible_o, 1'b0);
      check("R7 line_start in reset", line_start_o, 1'b0);
      rst = 1'b0;
      // three full frames plus a part line, compared every cycle (R3 R5)
      for (int i = 0; i < 3 * P_VS_END * (P_HLAST + 1) + 7; i++) begin
         @(negedge clk);
         compare_all();
      end
      // R8: reset in the middle of a frame
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check("R8 hsync after mid reset", hsync_o, 1'b1);
      check("R8 vsync after mid reset", vsync_o, 1'b1);
      rst = 1'b0;
      for (int i = 0; i < 2 * P_VS_END * (P_HLAST + 1); i++) begin
         @(negedge clk);
         compare_all();
      end
      done = 1'b1;
   end

   initial begin
      while (!done && cycles < 20000) @(negedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule